// File: doc/BRIEF.md
# Core Reset and Supply Status Controller

This block decides when the digital core of a radio transceiver is held in reset, and it reports on the health of the regulated supply. Three things can put the core into reset. The first is the chip's power-on reset. The second is an external active-low reset pin, which passes through a two-stage synchronizer. The third is a self-clearing software reset bit in the radio mode register. While the core is in reset, the mode register and the sticky supply flags go back to their defaults. A small register bus gives access to the mode register and to a status register.

The regulator supplies two comparator outputs, one for the low supply threshold and one for the high one. The status register shows both live comparator levels, a sticky drop flag for each threshold, and a ready flag. The ready flag rises once the high comparator has stayed high for a programmable number of consecutive cycles. Writing a mode that needs the regulator raises the regulator power-up request. A receive or transmit mode goes active only after the ready flag is set.

Top module: `rsb_ctrl`

## Requirements
- R1: While `por` is high, `core_rst` is 1 at every clock edge. After `por` falls, `core_rst` drops at the next edge if the pin is high. After power-on reset, the mode register reads 0 (OFF) and the sticky bits read 0.
- R2: The pin level passes through two synchronizer flops and then one output flop. When `ext_rst_n` goes low, `core_rst` rises on the third clock edge that samples it low. When `ext_rst_n` returns high, `core_rst` falls on the third edge that samples it high.
- R3: While `por` is high, `ext_rst_n` has no effect. When `por` is released with the pin high, no reset results.
- R4: Any core reset, whether from the pin or from software, returns the mode register to OFF and clears both sticky bits. Writes to the mode register are ignored while the internal reset is active.
- R5: Writing the mode register (address 0) with bit 7 set starts a software reset. The internal reset then lasts RST_CYC cycles, and `core_rst` follows it one cycle later. Bit 7 of the mode register reads 1 during this time and clears itself when the reset ends.
- R6: The status register (address 1) shows the live low-threshold comparator in bit 0 and the live high-threshold comparator in bit 1.
- R7: Each sticky bit is set at the clock edge that samples its comparator low. The low-threshold flag is status bit 2 and the high-threshold flag is status bit 3.
- R8: A read of address 1 (`rd_en` high) clears both sticky bits at that edge. If a comparator is low in the same cycle, its sticky bit stays set.
- R9: The mode codes in bits 2..0 are OFF=0, STANDBY=1, REGULATOR-ON=2, RX=4 and TX=5. A write with code 3, 6 or 7, or with any of bits 6..3 set, stores OFF. `reg_pwr_req` is 1 exactly while the mode is REGULATOR-ON, RX or TX.
- R10: The ready flag (status bit 4) is 1 once `cmp_hi` has been sampled high at READY_CYC consecutive edges. A single low sample clears it.
- R11: `radio_go` is 1 exactly while the mode is RX or TX and the ready flag is set.
- R12: A read of any address other than 0 or 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to `clk` |
| cmp_lo | input | 1 | Regulator above low threshold |
| cmp_hi | input | 1 | Regulator above high threshold |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| core_rst | output | 1 | Registered synchronous core reset |
| reg_pwr_req | output | 1 | Regulator power-up request |
| radio_go | output | 1 | Radio mode active with the supply ready |

## Verification
The assertions assume that both comparator inputs are already synchronous to `clk` and that `por` is high at the first edge. They also assume the bus drives `wr_en` and `rd_en` as single-cycle strobes with a stable `addr`. The stimulus changes every input only on the falling edge and holds `por` for several cycles at the start. It moves the comparators only between register accesses, except in the one case that deliberately makes a drop coincide with a clearing read. Because the pin goes through the synchronizer by design, the bench may drive it like any other input.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int REG_W      = 8;
    localparam int MODE_ADDR  = 0;
    localparam int STAT_ADDR  = 1;
    localparam int SW_RST_BIT = 7;

    typedef enum logic [2:0] {
        MODE_OFF   = 3'd0,
        MODE_STBY  = 3'd1,
        MODE_REGON = 3'd2,
        MODE_RX    = 3'd4,
        MODE_TX    = 3'd5
    } radio_mode_e;

    typedef struct packed {
        logic ready;
        logic stk_hi;
        logic stk_lo;
        logic live_hi;
        logic live_lo;
    } supply_stat_t;

    function automatic radio_mode_e decode_mode(input logic [REG_W-1:0] d);
        radio_mode_e m;
        m = MODE_OFF;
        if (d[6:3] == 4'd0) begin
            case (d[2:0])
                3'd1:    m = MODE_STBY;
                3'd2:    m = MODE_REGON;
                3'd4:    m = MODE_RX;
                3'd5:    m = MODE_TX;
                default: m = MODE_OFF;
            endcase
        end
        return m;
    endfunction

    function automatic logic needs_regulator(input radio_mode_e m);
        return (m == MODE_REGON) || (m == MODE_RX) || (m == MODE_TX);
    endfunction

    function automatic logic is_radio(input radio_mode_e m);
        return (m == MODE_RX) || (m == MODE_TX);
    endfunction

endpackage

// File: rtl/rsb_rst_seq.sv
module rsb_rst_seq #(
    parameter int RST_CYC = 4
) (
    input  logic clk,
    input  logic por,
    input  logic pin_n,
    input  logic sw_req,
    output logic intr,
    output logic sw_busy,
    output logic core_rst
);
    localparam int CNT_W = $clog2(RST_CYC + 1);

    logic             sync1, sync2;
    logic [CNT_W-1:0] sw_cnt;

    assign sw_busy = (sw_cnt != '0);
    assign intr    = !sync2 || sw_busy;

    always_ff @(posedge clk) begin
        if (por) begin
            sync1    <= 1'b1;
            sync2    <= 1'b1;
            sw_cnt   <= '0;
            core_rst <= 1'b1;
        end else begin
            sync1    <= pin_n;
            sync2    <= sync1;
            core_rst <= intr;
            if (sw_busy)
                sw_cnt <= sw_cnt - 1'b1;
            else if (sw_req && !intr)
                sw_cnt <= CNT_W'(RST_CYC);
        end
    end
endmodule

// File: rtl/rsb_supply_mon.sv
module rsb_supply_mon #(
    parameter int READY_CYC = 8
) (
    input  logic clk,
    input  logic por,
    input  logic intr,
    input  logic cmp_lo,
    input  logic cmp_hi,
    input  logic rd_clr,
    output logic stk_lo,
    output logic stk_hi,
    output logic ready
);
    localparam int HC_W = $clog2(READY_CYC + 1);

    logic [HC_W-1:0] hi_cnt;

    assign ready = (hi_cnt == HC_W'(READY_CYC));

    always_ff @(posedge clk) begin
        if (por) begin
            hi_cnt <= '0;
        end else if (!cmp_hi) begin
            hi_cnt <= '0;
        end else if (!ready) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (por || intr) begin
            stk_lo <= 1'b0;
            stk_hi <= 1'b0;
        end else begin
            stk_lo <= (stk_lo && !rd_clr) || !cmp_lo;
            stk_hi <= (stk_hi && !rd_clr) || !cmp_hi;
        end
    end
endmodule

// File: rtl/rsb_mode_reg.sv
module rsb_mode_reg
    import rsb_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             intr,
    input  logic             wr_mode,
    input  logic [REG_W-1:0] wdata,
    input  logic             ready,
    output radio_mode_e      mode,
    output logic             pwr_req,
    output logic             radio_go
);
    always_ff @(posedge clk) begin
        if (por || intr)
            mode <= MODE_OFF;
        else if (wr_mode)
            mode <= wdata[SW_RST_BIT] ? MODE_OFF : decode_mode(wdata);
    end

    assign pwr_req  = needs_regulator(mode);
    assign radio_go = is_radio(mode) && ready;
endmodule

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
    import rsb_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int RST_CYC   = 4,
    parameter int READY_CYC = 8
) (
    input  logic              clk,
    input  logic              por,
    input  logic              ext_rst_n,
    input  logic              cmp_lo,
    input  logic              cmp_hi,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              core_rst,
    output logic              reg_pwr_req,
    output logic              radio_go
);
    logic         core_int, sw_busy, sw_req, wr_mode, rd_clr;
    logic         stk_lo, stk_hi, ready;
    radio_mode_e  mode;
    supply_stat_t stat;

    assign wr_mode = wr_en && (addr == ADDR_W'(MODE_ADDR));
    assign sw_req  = wr_mode && wdata[SW_RST_BIT];
    assign rd_clr  = rd_en && (addr == ADDR_W'(STAT_ADDR));

    rsb_rst_seq #(.RST_CYC(RST_CYC)) u_rst (
        .clk(clk), .por(por), .pin_n(ext_rst_n), .sw_req(sw_req),
        .intr(core_int), .sw_busy(sw_busy), .core_rst(core_rst)
    );

    rsb_supply_mon #(.READY_CYC(READY_CYC)) u_mon (
        .clk(clk), .por(por), .intr(core_int), .cmp_lo(cmp_lo),
        .cmp_hi(cmp_hi), .rd_clr(rd_clr), .stk_lo(stk_lo),
        .stk_hi(stk_hi), .ready(ready)
    );

    rsb_mode_reg u_mode (
        .clk(clk), .por(por), .intr(core_int), .wr_mode(wr_mode),
        .wdata(wdata), .ready(ready), .mode(mode),
        .pwr_req(reg_pwr_req), .radio_go(radio_go)
    );

    always_comb begin
        stat.ready   = ready;
        stat.stk_hi  = stk_hi;
        stat.stk_lo  = stk_lo;
        stat.live_hi = cmp_hi;
        stat.live_lo = cmp_lo;
        if (addr == ADDR_W'(MODE_ADDR))
            rdata = {sw_busy, 4'b0000, mode};
        else if (addr == ADDR_W'(STAT_ADDR))
            rdata = {3'b000, stat};
        else
            rdata = '0;
    end
endmodule

// File: rtl/rsb_ctrl_chk.sv
module rsb_ctrl_chk (
    input logic clk,
    input logic por,
    input logic intr,
    input logic sw_busy,
    input logic core_rst,
    input logic cmp_lo,
    input logic cmp_hi,
    input logic rd_clr,
    input logic stk_lo,
    input logic stk_hi,
    input logic radio_go
);
    p_por_forces_rst_r1: assert property (@(posedge clk)
        por |=> core_rst);

    p_swrst_drives_core_r5: assert property (@(posedge clk) disable iff (por)
        $rose(sw_busy) |=> core_rst);

    p_sticky_lo_set_r7: assert property (@(posedge clk) disable iff (por)
        (!intr && !cmp_lo) |=> stk_lo);

    p_sticky_hi_set_r7: assert property (@(posedge clk) disable iff (por)
        (!intr && !cmp_hi) |=> stk_hi);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (por)
        (!intr && rd_clr && cmp_lo && cmp_hi) |=> (!stk_lo && !stk_hi));

    p_go_needs_supply_r10: assert property (@(posedge clk) disable iff (por)
        radio_go |-> $past(cmp_hi));
endmodule

bind rsb_ctrl rsb_ctrl_chk u_chk (
    .clk(clk), .por(por), .intr(core_int), .sw_busy(sw_busy),
    .core_rst(core_rst), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .rd_clr(rd_clr), .stk_lo(stk_lo), .stk_hi(stk_hi), .radio_go(radio_go)
);

// File: tb/sim_rsb_ctrl.sv
module sim_rsb_ctrl;
    localparam int RST   = 4;
    localparam int READY = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       por = 1'b1, pin = 1'b1, lo = 1'b1, hi = 1'b1, wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wd = 8'd0;
    logic [7:0] rdata;
    logic       core_rst, reg_pwr_req, radio_go;

    rsb_ctrl u0 (
        .clk(clk), .por(por), .ext_rst_n(pin), .cmp_lo(lo), .cmp_hi(hi),
        .wr_en(wr), .rd_en(rd), .addr(addr), .wdata(wd), .rdata(rdata),
        .core_rst(core_rst), .reg_pwr_req(reg_pwr_req), .radio_go(radio_go)
    );

    int    checks = 0, errors = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit q[$];
    int m_cnt, m_mode, m_hc;
    bit m_core, m_slo, m_shi;

    function automatic int legal_mode(input int d);
        if (d[7]) return 0;
        if ((d & 8'h78) != 0) return 0;
        if ((d & 7) inside {1, 2, 4, 5}) return d & 7;
        return 0;
    endfunction

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        q = '{1'b1, 1'b1};
        m_cnt = 0; m_core = 1; m_mode = 0; m_slo = 0; m_shi = 0; m_hc = 0;
    endtask

    task automatic cyc(input bit p_por, p_pin, p_lo, p_hi, p_wr, p_rd,
                       input int p_addr, input int p_wd);
        logic [7:0] e_rd;
        bit intr, clr;
        @(negedge clk);
        por = p_por; pin = p_pin; lo = p_lo; hi = p_hi; wr = p_wr; rd = p_rd;
        addr = 2'(p_addr); wd = 8'(p_wd);
        #1;
        if (p_addr == 0) e_rd = {(m_cnt != 0), 4'b0, 3'(m_mode)};
        else if (p_addr == 1) e_rd = {3'b0, (m_hc == READY), m_shi, m_slo, p_hi, p_lo};
        else e_rd = 8'd0;
        chk("core_rst", 8'(core_rst), 8'(m_core));
        chk("reg_pwr_req", 8'(reg_pwr_req), 8'(m_mode inside {2, 4, 5}));
        chk("radio_go", 8'(radio_go), 8'((m_mode inside {4, 5}) && m_hc == READY));
        chk("rdata", rdata, e_rd);
        @(posedge clk);
        if (p_por) begin
            model_reset();
        end else begin
            intr = (q[0] == 1'b0) || (m_cnt != 0);
            clr  = p_rd && p_addr == 1;
            m_core = intr;
            if (m_cnt != 0) m_cnt--;
            else if (p_wr && p_addr == 0 && p_wd[7] && !intr) m_cnt = RST;
            if (intr) m_mode = 0;
            else if (p_wr && p_addr == 0) m_mode = legal_mode(p_wd);
            if (intr) begin m_slo = 0; m_shi = 0; end
            else begin
                m_slo = !p_lo || (m_slo && !clr);
                m_shi = !p_hi || (m_shi && !clr);
            end
            m_hc = p_hi ? ((m_hc < READY) ? m_hc + 1 : READY) : 0;
            void'(q.pop_front());
            q.push_back(p_pin);
        end
    endtask

    task automatic idle(input int n, input int a);
        for (int i = 0; i < n; i++) cyc(0, 1, 1, 1, 0, 0, a, 0);
    endtask

    initial begin
        model_reset();
        // R1 and R3: por held, pin toggling has no effect
        cur_req = "R3";
        cyc(1, 0, 1, 1, 0, 0, 0, 0);
        cyc(1, 0, 1, 1, 0, 0, 0, 0);
        cyc(1, 1, 1, 1, 0, 0, 1, 0);
        cyc(1, 0, 1, 1, 0, 0, 1, 0);
        cyc(1, 1, 1, 1, 0, 0, 0, 0);
        cur_req = "R1";
        idle(3, 0);
        idle(2, 1);
        // R12: reserved addresses
        cur_req = "R12";
        idle(2, 2);
        idle(1, 3);
        // R10: ready builds up
        cur_req = "R10";
        idle(READY + 2, 1);
        // R9 and R11: radio modes
        cur_req = "R9";
        cyc(0, 1, 1, 1, 1, 0, 0, 8'h02); idle(2, 0);
        cyc(0, 1, 1, 1, 1, 0, 0, 8'h01); idle(2, 0);
        cyc(0, 1, 1, 1, 1, 0, 0, 8'h03); idle(2, 0);
        cyc(0, 1, 1, 1, 1, 0, 0, 8'h0C); idle(2, 0);
        cyc(0, 1, 1, 1, 1, 0, 0, 8'h07); idle(1, 0);
        cur_req = "R11";
        cyc(0, 1, 1, 1, 1, 0, 0, 8'h04); idle(2, 1);
        cyc(0, 1, 1, 1, 1, 0, 0, 8'h05); idle(2, 0);
        // R7 and R10: high threshold drop
        cur_req = "R7";
        cyc(0, 1, 1, 0, 0, 0, 1, 0);
        idle(3, 1);
        cur_req = "R10";
        idle(READY + 1, 1);
        // R6: live bits alone
        cur_req = "R6";
        cyc(0, 1, 0, 1, 0, 0, 1, 0);
        cyc(0, 1, 0, 0, 0, 0, 1, 0);
        cyc(0, 1, 1, 0, 0, 0, 1, 0);
        idle(1, 1);
        // R8: clear on read, then set wins
        cur_req = "R8";
        cyc(0, 1, 1, 1, 0, 1, 1, 0);
        idle(2, 1);
        cyc(0, 1, 0, 1, 0, 0, 1, 0);
        cyc(0, 1, 0, 1, 0, 1, 1, 0);
        idle(2, 1);
        cyc(0, 1, 1, 1, 0, 1, 0, 0);
        idle(1, 1);
        cyc(0, 1, 1, 1, 0, 1, 1, 0);
        idle(READY + 1, 1);
        // R5 and R4: software reset
        cur_req = "R5";
        cyc(0, 1, 1, 1, 1, 0, 0, 8'h04);
        cyc(0, 1, 0, 1, 0, 0, 0, 0);
        cyc(0, 1, 1, 1, 1, 0, 0, 8'h80);
        idle(2, 0);
        cyc(0, 1, 1, 1, 1, 0, 0, 8'h05);
        idle(RST + 2, 0);
        cur_req = "R4";
        idle(2, 1);
        // R2 and R4: external pin reset
        cur_req = "R2";
        cyc(0, 1, 1, 1, 1, 0, 0, 8'h02);
        cyc(0, 1, 0, 1, 0, 0, 1, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 1, 0, 0, 8'h04);
        cur_req = "R4";
        cyc(0, 0, 1, 1, 0, 0, 1, 0);
        cur_req = "R2";
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 0, 0, 0);
        idle(5, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule